// File: doc/BRIEF.md
# Code Word Pulse Modulator

This block turns one parallel code word into a timed serial waveform on a single output pin. It supports two line codes. The first is fixed-period pulse-width modulation, in which every bit starts high and its value sets how long it stays high. The second is variable pulse-width modulation, in which the line changes level at every bit boundary and the value sets how long the bit lasts. Every word has the same framing: an optional wake-up burst with a quiet gap, then an alternating preamble, a low header, one sync element, the data bits with the least significant bit first, and a low guard interval. A one-clock done strobe follows the guard.

Timing comes from a base tick input. Each tick marks one 100 µs unit. An element lasts 1, 2 or 4 ticks, chosen by the baud-select and format configuration bits. Code words enter on a valid/ready stream port. The port accepts a word only while the block is idle, so `frame_ready` stays low from acceptance until the cycle after the done strobe. An upstream source with a word pending just holds `frame_valid` and the word steady until it is taken. The configuration pins and the first-word flag are sampled at acceptance and held for the whole word.

Top module: `cw_modulator`

## Requirements
- R1: `frame_ready` is high only while idle. A word is taken on a clock where `frame_valid` and `frame_ready` are both high, and `frame_ready` then stays low until the cycle after `done_o`. A `frame_valid` raised while busy is ignored and does not alter the waveform of the word in flight.
- R2: An element lasts this many base ticks. With `cfg_vpwm`=0, {`cfg_fmt`,`cfg_baud`} = 00, 01, 10, 11 gives 4, 2, 2, 1. With `cfg_vpwm`=1, `cfg_baud`=0 gives 4 and `cfg_baud`=1 gives 2. Between ticks the output holds its level.
- R3: When `cfg_vpwm`=1, `cfg_fmt`=1 and `frame_first`=1, the word is preceded by 24 wake-up elements that alternate high and low, starting high, and then 20 low elements. In every other case there is no wake-up and no gap.
- R4: The preamble is 23 elements alternating high and low, starting and ending high. It is followed by a 10-element low header.
- R5: After the header comes one sync element. It is steady high when `cfg_sync_mod`=0. When `cfg_sync_mod`=1 it is high on the first tick of the element and changes level on every following tick.
- R6: In pulse-width mode each bit spans 3 elements when `cfg_fmt`=0 and 6 elements when `cfg_fmt`=1. A 1 is high for one element and a 0 is high for two, with the rest of the span low. Bit 0 goes first.
- R7: In variable mode a 1 lasts one element and a 0 lasts two. Bits with an even index are high and bits with an odd index are low, so bit 0 is high.
- R8: After the last bit the output is low for 15 elements in pulse-width mode or 30 in variable mode. `done_o` then rises for exactly one clock, in the cycle after the tick that ends the guard, and never at any other time.
- R9: Changing the configuration pins or `frame_first` while a word is in flight has no effect on that word.
- R10: After reset, and whenever idle, `data_o` and `done_o` are low and `frame_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Code word offered |
| frame_ready | output | 1 | Block idle, word will be taken |
| frame_data | input | 67 | Code word, bit 0 sent first |
| frame_first | input | 1 | Word is the first of a transmission |
| tick_i | input | 1 | One-clock base timing tick (100 µs unit) |
| cfg_vpwm | input | 1 | 1 selects variable pulse-width coding |
| cfg_baud | input | 1 | 1 selects the faster rate |
| cfg_fmt | input | 1 | Short-duty format (pulse width) or wake-up enable (variable) |
| cfg_sync_mod | input | 1 | 1 chops the sync element at tick rate |
| data_o | output | 1 | Serial modulated output |
| done_o | output | 1 | One-clock pulse after the guard interval |

## Verification
The bench goes after every element length in the rate table. A design that decoded the format bit wrongly in one mode would stretch or squeeze every element, and the whole waveform would slip. It checks the wake-up condition in all three of its gating cases. A design that ignored the first-word flag or the mode would add or drop 44 elements. It sends words whose bit patterns exercise both bit values at both parities of the bit index. A wrong parity rule or an off-by-one bit count would shift the edges that follow, and a missing least-significant-first order would reverse the bit pattern. It also offers a second word and flips every configuration pin in the middle of a word. Either a leaked capture or a ready that went high early would corrupt the sampled waveform or the ready check.

// File: rtl/cw_mod_pkg.sv
package cw_mod_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_WAKE, PH_DEAD, PH_PRE, PH_HDR,
    PH_SYNC, PH_DATA, PH_GUARD, PH_DONE
  } phase_e;

  localparam int SUB_W = 2;   // ticks-per-element counter, up to 4 ticks
endpackage

// File: rtl/cw_elem_timer.sv
module cw_elem_timer
  import cw_mod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       te_log,
  output logic [SUB_W-1:0] sub,
  output logic             elem_end
);
  logic [SUB_W-1:0] last;

  always_comb begin
    last     = SUB_W'((3'd1 << te_log) - 3'd1);
    elem_end = run && tick && (sub == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sub <= '0;
    else if (!run)    sub <= '0;
    else if (tick)    sub <= elem_end ? '0 : sub + 1'b1;
  end

  // R2: tick position never passes the element length
  assert_sub_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (sub <= last));
  // R2: level position only moves on a tick
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (sub == $past(sub)));
endmodule

// File: rtl/cw_level_enc.sv
module cw_level_enc
  import cw_mod_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [SUB_W-1:0] sub,
  input  logic             vpwm,
  input  logic             sync_mod,
  input  logic             bit_val,
  input  logic             bit_odd,
  output logic             level
);
  logic [CNT_W-1:0] hi_len;

  always_comb begin
    hi_len = bit_val ? CNT_W'(1) : CNT_W'(2);
    unique case (phase)
      PH_WAKE, PH_PRE: level = ~elem_cnt[0];
      PH_SYNC:         level = sync_mod ? ~sub[0] : 1'b1;
      PH_DATA:         level = vpwm ? ~bit_odd : (elem_cnt < hi_len);
      default:         level = 1'b0;
    endcase
  end
endmodule

// File: rtl/cw_modulator.sv
module cw_modulator
  import cw_mod_pkg::*;
#(
  parameter int FRAME_W    = 67,
  parameter int WAKE_LEN   = 24,
  parameter int DEAD_LEN   = 20,
  parameter int PRE_LEN    = 23,
  parameter int HDR_LEN    = 10,
  parameter int GUARD_PWM  = 15,
  parameter int GUARD_VPWM = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               frame_first,
  input  logic               tick_i,
  input  logic               cfg_vpwm,
  input  logic               cfg_baud,
  input  logic               cfg_fmt,
  input  logic               cfg_sync_mod,
  output logic               data_o,
  output logic               done_o
);
  localparam int MAXLEN = WAKE_LEN + DEAD_LEN + PRE_LEN + HDR_LEN + GUARD_VPWM + 6;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int IDX_W  = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);

  phase_e             phase, nxt;
  logic [CNT_W-1:0]   elem_cnt, plen, blen;
  logic [IDX_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic               vpwm_q, baud_q, fmt_q, sm_q;
  logic [1:0]         te_log;
  logic [SUB_W-1:0]   sub;
  logic               elem_end, run;

  assign frame_ready = (phase == PH_IDLE);
  assign done_o      = (phase == PH_DONE);
  assign run         = !frame_ready && !done_o;

  always_comb begin
    if (vpwm_q) te_log = baud_q ? 2'd1 : 2'd2;
    else        te_log = 2'd2 - {1'b0, baud_q} - {1'b0, fmt_q};
    blen = vpwm_q ? (shreg[0] ? CNT_W'(1) : CNT_W'(2)) : (fmt_q ? CNT_W'(6) : CNT_W'(3));
    plen = CNT_W'(1);
    nxt  = PH_IDLE;
    unique case (phase)
      PH_WAKE:  begin plen = CNT_W'(WAKE_LEN); nxt = PH_DEAD;  end
      PH_DEAD:  begin plen = CNT_W'(DEAD_LEN); nxt = PH_PRE;   end
      PH_PRE:   begin plen = CNT_W'(PRE_LEN);  nxt = PH_HDR;   end
      PH_HDR:   begin plen = CNT_W'(HDR_LEN);  nxt = PH_SYNC;  end
      PH_SYNC:  begin plen = CNT_W'(1);        nxt = PH_DATA;  end
      PH_DATA:  begin plen = blen;             nxt = PH_GUARD; end
      PH_GUARD: begin
        plen = vpwm_q ? CNT_W'(GUARD_VPWM) : CNT_W'(GUARD_PWM);
        nxt  = PH_DONE;
      end
      default:  ;
    endcase
  end

  cw_elem_timer i_timer (
    .clk, .rst_n, .run, .tick(tick_i), .te_log, .sub, .elem_end
  );

  cw_level_enc #(.CNT_W(CNT_W)) i_enc (
    .phase, .elem_cnt, .sub, .vpwm(vpwm_q), .sync_mod(sm_q),
    .bit_val(shreg[0]), .bit_odd(bit_idx[0]), .level(data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; elem_cnt <= '0; bit_idx <= '0; shreg <= '0;
      vpwm_q <= 1'b0; baud_q <= 1'b0; fmt_q <= 1'b0; sm_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (frame_valid) begin
          shreg  <= frame_data;
          vpwm_q <= cfg_vpwm; baud_q <= cfg_baud;
          fmt_q  <= cfg_fmt;  sm_q   <= cfg_sync_mod;
          elem_cnt <= '0; bit_idx <= '0;
          phase  <= (cfg_vpwm && cfg_fmt && frame_first) ? PH_WAKE : PH_PRE;
        end
        PH_DONE: phase <= PH_IDLE;
        default: if (elem_end) begin
          if (elem_cnt == plen - 1'b1) begin
            elem_cnt <= '0;
            if (phase == PH_DATA && bit_idx != LAST_BIT) begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
            end else begin
              phase <= nxt;
            end
          end else begin
            elem_cnt <= elem_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R1: taking a word closes the port
  assert_accept_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ready) |=> !frame_ready);
  // R4: header is quiet
  assert_header_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR) |-> !data_o);
  // R8: guard is quiet
  assert_guard_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GUARD) |-> !data_o);
  // R8: done is a single clock and reopens the port
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && frame_ready));
  // R9: captured settings frozen while busy
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ready |=> ($stable(vpwm_q) && $stable(baud_q) && $stable(fmt_q) && $stable(sm_q)));
  // R10: idle output quiet
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (!data_o && !done_o));
endmodule

// File: tb/test_cw_modulator.sv
module test_cw_modulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0, frame_first = 1'b0, tick_i = 1'b0;
  logic [66:0] frame_data = '0;
  logic        cfg_vpwm = 1'b0, cfg_baud = 1'b0, cfg_fmt = 1'b0, cfg_sync_mod = 1'b0;
  logic        frame_ready, data_o, done_o;

  always #2 clk = ~clk;   // 250 MHz

  cw_modulator i_cw_modulator (
    .clk, .rst_n, .frame_valid, .frame_ready, .frame_data, .frame_first,
    .tick_i, .cfg_vpwm, .cfg_baud, .cfg_fmt, .cfg_sync_mod, .data_o, .done_o
  );

  int n_cmp = 0, n_bad = 0;
  bit exp_w [0:1499];
  int n_exp;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit lvl, input int cnt);
    for (int k = 0; k < cnt; k++) begin exp_w[n_exp] = lvl; n_exp++; end
  endtask

  // Expected per-tick waveform, written from the requirements
  task automatic build(input logic [66:0] f, input bit vp, input bit bd,
                       input bit fm, input bit sm, input bit first);
    int te, per, hi;
    n_exp = 0;
    if (vp) te = bd ? 2 : 4;                         // R2
    else    te = fm ? (bd ? 1 : 2) : (bd ? 2 : 4);
    if (vp && fm && first) begin                      // R3
      for (int e = 0; e < 24; e++) push(e % 2 == 0, te);
      push(1'b0, 20 * te);
    end
    for (int e = 0; e < 23; e++) push(e % 2 == 0, te); // R4
    push(1'b0, 10 * te);
    for (int s = 0; s < te; s++) push(sm ? (s % 2 == 0) : 1'b1, 1); // R5
    for (int i = 0; i < 67; i++) begin
      if (vp) push(i % 2 == 0, (f[i] ? 1 : 2) * te);  // R7
      else begin                                       // R6
        per = fm ? 6 : 3; hi = f[i] ? 1 : 2;
        push(1'b1, hi * te); push(1'b0, (per - hi) * te);
      end
    end
    push(1'b0, (vp ? 30 : 15) * te);                  // R8
  endtask

  task automatic run_frame(input string tag, input logic [66:0] f, input bit vp,
                           input bit bd, input bit fm, input bit sm,
                           input bit first, input bit disturb);
    int bad_at, bad_act, dones;
    build(f, vp, bd, fm, sm, first);
    frame_data = f; cfg_vpwm = vp; cfg_baud = bd; cfg_fmt = fm;
    cfg_sync_mod = sm; frame_first = first; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    check(frame_ready == 1'b0, "R1", {tag, " ready low after accept"}, frame_ready, 0);
    bad_at = -1; bad_act = 0; dones = 0;
    for (int j = 0; j < n_exp; j++) begin
      if (data_o !== exp_w[j] && bad_at < 0) begin bad_at = j; bad_act = data_o; end
      if (done_o) dones++;
      if (disturb && j == 5) begin                    // R9, R1
        frame_valid = 1'b1; frame_data = ~f; cfg_vpwm = ~vp; cfg_baud = ~bd;
        cfg_fmt = ~fm; cfg_sync_mod = ~sm; frame_first = ~first;
      end
      if (disturb && j == 9) begin
        check(frame_ready == 1'b0, "R1", {tag, " ready while busy"}, frame_ready, 0);
        frame_valid = 1'b0;
      end
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      if (j != n_exp - 1) begin
        if (done_o) dones++;
        @(negedge clk); @(negedge clk);
      end
    end
    check(bad_at < 0, tag, $sformatf("waveform at tick %0d", bad_at), bad_act,
          bad_at < 0 ? 0 : int'(exp_w[bad_at]));
    check(dones == 0, "R8", {tag, " no early done"}, dones, 0);
    check(done_o == 1'b1, "R8", {tag, " done after guard"}, done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0 && frame_ready == 1'b1, "R8",
          {tag, " done single, ready back"}, {done_o, frame_ready}, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(frame_ready == 1'b1, "R10", "ready after reset", frame_ready, 1);
    check(data_o == 1'b0 && done_o == 1'b0, "R10", "outputs low after reset",
          {data_o, done_o}, 0);
  endtask

  task automatic t_pwm_slow;     // R2 R4 R5 R6 R8: 4 ticks/element
    run_frame("R6 pwm 1/3 slow", 67'h5_A5A5_0F0F_3C3C_9669, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic t_pwm_fast;     // R2 R6: 2 ticks/element, 1/3 format
    run_frame("R2 pwm 1/3 fast", 67'h7_1234_5678_9ABC_DEF0, 0, 1, 0, 0, 1, 0);
  endtask
  task automatic t_pwm_sixth;    // R5 R6: 1/6 format, chopped sync
    run_frame("R5 pwm 1/6 slow", 67'h2_FFFF_0000_AAAA_5555, 0, 0, 1, 1, 0, 0);
  endtask
  task automatic t_pwm_sixth_fast; // R2 R3: 1 tick/element, no wake in pwm
    run_frame("R3 pwm 1/6 fast", 67'h4_8001_7FFE_C003_1248, 0, 1, 1, 0, 1, 0);
  endtask
  task automatic t_vpwm_wake;    // R3 R7: wake-up on first word
    run_frame("R3 vpwm wake", 67'h1_3579_BDF0_2468_ACE1, 1, 1, 1, 1, 1, 0);
  endtask
  task automatic t_vpwm_nofirst; // R3 R7: not first, no wake
    run_frame("R7 vpwm no first", 67'h6_0F1E_2D3C_4B5A_6978, 1, 1, 1, 0, 0, 0);
  endtask
  task automatic t_vpwm_slow;    // R2 R5 R7: 4 ticks/element, chopped sync
    run_frame("R7 vpwm slow", 67'h3_C3C3_A5A5_0001_8000, 1, 0, 0, 1, 1, 0);
  endtask
  task automatic t_disturb;      // R1 R9: offer and reconfigure while busy
    run_frame("R9 mid-word changes", 67'h0_DEAD_BEEF_CAFE_F00D, 1, 0, 1, 0, 1, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm_slow();
    t_pwm_fast();
    t_pwm_sixth();
    t_pwm_sixth_fast();
    t_vpwm_wake();
    t_vpwm_nofirst();
    t_vpwm_slow();
    t_disturb();
    t_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule